// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides how a small processor core parks itself in a low-power state and how it comes back. While the core is running, an idle request makes the block read a 2-bit mode value and move into one of three parked states. Each state turns off its own set of clocks: the oscillator enable, the PLL enable, the core clock enable and the system clock-out enable. Each state also listens to its own set of wake sources. All of the wake sources are active low: GPIO lines picked by a 32-bit select mask, a watchdog interrupt, an external reset, a debugger request and an enabled interrupt.

In the middle (standby) state a selected GPIO line must stay low for a programmed number of oscillator clocks before the wake is accepted. A shorter pulse resets the filter and the block stays parked. When a wake is accepted, the clocks come back one group per cycle in a fixed order. The block then gives a one-cycle wake strobe and returns to running. The block only drives clock and oscillator enables. It never touches pin states. Clock generation, PLL lock timing, the watchdog counter and the interrupt controller are outside the block and reach it as plain inputs.

Top module: `lpm_seq`

## Requirements
- R1: From RUN, a high `idle_req` samples `lp_mode`: 00 enters IDLE, 01 enters STANDBY, and 10 or 11 enter HALT. `idle_req` has no effect in any other state.
- R2: In IDLE, `osc_en`, `pll_en`, `cpu_clk_en` and `clkout_en` are all 1 and `in_lowpower` is 1.
- R3: IDLE ends when `irq_n` or `wdog_irq_n` is sampled low. The next cycle is the wake-strobe cycle, and RUN follows one cycle after that.
- R4: In STANDBY, `osc_en` and `pll_en` are 1, `cpu_clk_en` and `clkout_en` are 0, and `in_lowpower` is 1. The core clock is never on while the oscillator is off.
- R5: STANDBY ends at once when `wdog_irq_n` or `dbg_req_n` is sampled low.
- R6: In STANDBY, a GPIO wake is accepted on the (`qual_len`+2)-th consecutive clock edge at which a selected line is sampled low, which gives 2 to 65 clocks. If no selected line is low at an edge, the count returns to zero and the block stays in STANDBY.
- R7: In HALT all four enables are 0 and `in_lowpower` is 1. A selected GPIO line low, with no filtering, or `wdog_irq_n` low ends HALT. `dbg_req_n` and `irq_n` have no effect in HALT.
- R8: A HALT request made while `wdclk_ok` is 0 is refused, and the block stays in RUN with all clocks on.
- R9: After a STANDBY or HALT wake the enables return in order, one step per cycle. First come `osc_en` and `pll_en`, with core clock and clock-out still off. Next `cpu_clk_en` turns on. Then `clkout_en` turns on. RUN has all four on and `in_lowpower` at 0.
- R10: `wake_pulse` is high for exactly one cycle, after all clocks are back. The block is in RUN on the next cycle.
- R11: `ext_rst_n` low at an edge puts the block in RUN with all enables on and clears any filter count. This has priority over everything else.
- R12: A GPIO line whose `wake_sel` bit is 0 never wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Core asks to enter the selected low-power state |
| lp_mode | input | 2 | Low-power state select |
| qual_len | input | 6 | STANDBY GPIO filter length minus two |
| wake_sel | input | 32 | GPIO wake enable mask |
| gpio_n | input | 32 | GPIO wake lines, active low |
| wdog_irq_n | input | 1 | Watchdog interrupt, active low |
| ext_rst_n | input | 1 | External reset, active low |
| dbg_req_n | input | 1 | Debugger wake request, active low |
| irq_n | input | 1 | Any enabled interrupt, active low |
| wdclk_ok | input | 1 | Watchdog clock is running |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | Core clock enable |
| clkout_en | output | 1 | System clock-out enable |
| wake_pulse | output | 1 | One-cycle strobe on return to RUN |
| in_lowpower | output | 1 | High in IDLE, STANDBY or HALT |

## Verification
The bench aims at the edges of the GPIO filter. It checks that a low pulse one clock short of `qual_len`+2 leaves STANDBY untouched, and it tests the shortest and longest settings. A filter that is off by one would wake early or never wake. It also checks that the external reset clears a filter count already in progress: a design that kept the count would wake too soon after the next entry into STANDBY. The bench sends wake sources to states that must ignore them: a debugger request in HALT, an unselected GPIO line, and a second idle request in STANDBY. It also makes a HALT request while the watchdog clock is reported off, which must leave all clocks running. The restore sequence is checked cycle by cycle, so a design that turns the clocks back on in the wrong order, or that stretches the wake strobe, is caught.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_STBY,
        ST_HALT,
        ST_UP_OSC,
        ST_UP_CPU,
        ST_UP_OUT,
        ST_WAKE
    } lpm_state_e;

    typedef enum logic [1:0] {
        LP_IDLE = 2'b00,
        LP_STBY = 2'b01,
        LP_HALT = 2'b10
    } lp_kind_e;

    typedef struct packed {
        logic osc;
        logic pll;
        logic cpu;
        logic out;
    } clk_gates_t;

    function automatic lp_kind_e decode_mode(input logic [1:0] m);
        if (m[1])
            return LP_HALT;
        else if (m[0])
            return LP_STBY;
        else
            return LP_IDLE;
    endfunction

    function automatic clk_gates_t gates_of(input lpm_state_e s);
        clk_gates_t g;
        case (s)
            ST_STBY:   g = '{osc: 1'b1, pll: 1'b1, cpu: 1'b0, out: 1'b0};
            ST_HALT:   g = '{osc: 1'b0, pll: 1'b0, cpu: 1'b0, out: 1'b0};
            ST_UP_OSC: g = '{osc: 1'b1, pll: 1'b1, cpu: 1'b0, out: 1'b0};
            ST_UP_CPU: g = '{osc: 1'b1, pll: 1'b1, cpu: 1'b1, out: 1'b0};
            default:   g = '{osc: 1'b1, pll: 1'b1, cpu: 1'b1, out: 1'b1};
        endcase
        return g;
    endfunction

    function automatic logic is_parked(input lpm_state_e s);
        return (s == ST_IDLE) || (s == ST_STBY) || (s == ST_HALT);
    endfunction

endpackage

// File: rtl/lpm_gpio_sel.sv
module lpm_gpio_sel #(
    parameter int NUM_GPIO = 32
) (
    input  logic [NUM_GPIO-1:0] gpio_n,
    input  logic [NUM_GPIO-1:0] sel,
    output logic                hit
);
    logic [NUM_GPIO-1:0] line_hit;

    for (genvar i = 0; i < NUM_GPIO; i++) begin : g_line
        assign line_hit[i] = sel[i] & ~gpio_n[i];
    end

    assign hit = |line_hit;
endmodule

// File: rtl/lpm_qual_filter.sv
module lpm_qual_filter #(
    parameter int QUAL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              level,
    input  logic [QUAL_W-1:0] qual,
    output logic              done
);
    localparam int CW = QUAL_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = CW'(qual) + CW'(1);
    assign done = level && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !level)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/lpm_wake_mux.sv
module lpm_wake_mux
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    input  logic       gpio_hit,
    input  logic       gpio_qual,
    input  logic       wdog_irq_n,
    input  logic       dbg_req_n,
    input  logic       irq_n,
    output logic       wake
);
    always_comb begin
        case (state)
            ST_IDLE: wake = !irq_n || !wdog_irq_n;
            ST_STBY: wake = gpio_qual || !wdog_irq_n || !dbg_req_n;
            ST_HALT: wake = gpio_hit || !wdog_irq_n;
            default: wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int NUM_GPIO = 32,
    parameter int QUAL_W   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idle_req,
    input  logic [1:0]          lp_mode,
    input  logic [QUAL_W-1:0]   qual_len,
    input  logic [NUM_GPIO-1:0] wake_sel,
    input  logic [NUM_GPIO-1:0] gpio_n,
    input  logic                wdog_irq_n,
    input  logic                ext_rst_n,
    input  logic                dbg_req_n,
    input  logic                irq_n,
    input  logic                wdclk_ok,
    output logic                osc_en,
    output logic                pll_en,
    output logic                cpu_clk_en,
    output logic                clkout_en,
    output logic                wake_pulse,
    output logic                in_lowpower
);
    lpm_state_e state, nxt;
    clk_gates_t gates;
    logic       gpio_hit, gpio_qual, wake;

    lpm_gpio_sel #(.NUM_GPIO(NUM_GPIO)) u_sel (
        .gpio_n (gpio_n),
        .sel    (wake_sel),
        .hit    (gpio_hit)
    );

    lpm_qual_filter #(.QUAL_W(QUAL_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .clear ((state != ST_STBY) || !ext_rst_n),
        .level (gpio_hit),
        .qual  (qual_len),
        .done  (gpio_qual)
    );

    lpm_wake_mux u_mux (
        .state      (state),
        .gpio_hit   (gpio_hit),
        .gpio_qual  (gpio_qual),
        .wdog_irq_n (wdog_irq_n),
        .dbg_req_n  (dbg_req_n),
        .irq_n      (irq_n),
        .wake       (wake)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN: begin
                if (idle_req) begin
                    case (decode_mode(lp_mode))
                        LP_IDLE: nxt = ST_IDLE;
                        LP_STBY: nxt = ST_STBY;
                        default: nxt = wdclk_ok ? ST_HALT : ST_RUN;
                    endcase
                end
            end
            ST_IDLE:   if (wake) nxt = ST_WAKE;
            ST_STBY:   if (wake) nxt = ST_UP_OSC;
            ST_HALT:   if (wake) nxt = ST_UP_OSC;
            ST_UP_OSC: nxt = ST_UP_CPU;
            ST_UP_CPU: nxt = ST_UP_OUT;
            ST_UP_OUT: nxt = ST_WAKE;
            default:   nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !ext_rst_n)
            state <= ST_RUN;
        else
            state <= nxt;
    end

    assign gates       = gates_of(state);
    assign osc_en      = gates.osc;
    assign pll_en      = gates.pll;
    assign cpu_clk_en  = gates.cpu;
    assign clkout_en   = gates.out;
    assign wake_pulse  = (state == ST_WAKE);
    assign in_lowpower = is_parked(state);
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       idle_req,
    input logic [1:0] lp_mode,
    input logic       wdclk_ok,
    input logic       ext_rst_n,
    input logic       osc_en,
    input logic       pll_en,
    input logic       cpu_clk_en,
    input logic       clkout_en,
    input logic       wake_pulse,
    input logic       in_lowpower
);
    p_ext_reset_r11: assert property (@(posedge clk) disable iff (rst)
        !ext_rst_n |=> (osc_en && pll_en && cpu_clk_en && clkout_en && !in_lowpower));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    p_pulse_clocks_up_r10: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (osc_en && pll_en && cpu_clk_en && clkout_en && !in_lowpower));

    p_cpu_after_osc_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_clk_en) && $past(ext_rst_n)) |-> $past(osc_en));

    p_out_after_cpu_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(clkout_en) && $past(ext_rst_n)) |-> $past(cpu_clk_en));

    p_no_cpu_without_osc_r4: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !pll_en));

    p_halt_refused_r8: assert property (@(posedge clk) disable iff (rst)
        (idle_req && lp_mode[1] && !wdclk_ok && ext_rst_n && !in_lowpower && clkout_en)
        |=> (osc_en && cpu_clk_en));
endmodule

bind lpm_seq lpm_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .idle_req    (idle_req),
    .lp_mode     (lp_mode),
    .wdclk_ok    (wdclk_ok),
    .ext_rst_n   (ext_rst_n),
    .osc_en      (osc_en),
    .pll_en      (pll_en),
    .cpu_clk_en  (cpu_clk_en),
    .clkout_en   (clkout_en),
    .wake_pulse  (wake_pulse),
    .in_lowpower (in_lowpower)
);

// File: tb/lpm_seq_test.sv
module lpm_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        idle_req;
    logic [1:0]  lp_mode;
    logic [5:0]  qual_len;
    logic [31:0] wake_sel;
    logic [31:0] gpio_n;
    logic        wdog_irq_n, ext_rst_n, dbg_req_n, irq_n, wdclk_ok;
    logic        osc_en, pll_en, cpu_clk_en, clkout_en, wake_pulse, in_lowpower;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    // {osc, pll, cpu, out, lowpower}
    localparam logic [4:0] G_RUN  = 5'b11110;
    localparam logic [4:0] G_IDLE = 5'b11111;
    localparam logic [4:0] G_STBY = 5'b11001;
    localparam logic [4:0] G_HALT = 5'b00001;
    localparam logic [4:0] G_UOSC = 5'b11000;
    localparam logic [4:0] G_UCPU = 5'b11100;

    // {lp_mode, wdclk_ok, expected gates}
    localparam logic [7:0] VEC [0:4] = '{
        {2'b00, 1'b1, G_IDLE},
        {2'b01, 1'b1, G_STBY},
        {2'b10, 1'b1, G_HALT},
        {2'b11, 1'b1, G_HALT},
        {2'b10, 1'b0, G_RUN}
    };

    always #2 clk = ~clk;

    lpm_seq uut (
        .clk(clk), .rst(rst), .idle_req(idle_req), .lp_mode(lp_mode),
        .qual_len(qual_len), .wake_sel(wake_sel), .gpio_n(gpio_n),
        .wdog_irq_n(wdog_irq_n), .ext_rst_n(ext_rst_n), .dbg_req_n(dbg_req_n),
        .irq_n(irq_n), .wdclk_ok(wdclk_ok), .osc_en(osc_en), .pll_en(pll_en),
        .cpu_clk_en(cpu_clk_en), .clkout_en(clkout_en), .wake_pulse(wake_pulse),
        .in_lowpower(in_lowpower)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [4:0] exp, input string tag);
        logic [4:0] got;
        got = {osc_en, pll_en, cpu_clk_en, clkout_en, in_lowpower};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s gates got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic chk_pulse(input logic exp, input string tag);
        total++;
        if (wake_pulse !== exp) begin
            bad++;
            $display("FAIL %s wake_pulse got=%b exp=%b", tag, wake_pulse, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; idle_req = 1'b0; lp_mode = 2'b00; qual_len = 6'd3;
        wake_sel = 32'h0000_0001; gpio_n = '1; wdog_irq_n = 1'b1;
        ext_rst_n = 1'b1; dbg_req_n = 1'b1; irq_n = 1'b1; wdclk_ok = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic enter(input logic [1:0] m);
        lp_mode = m; idle_req = 1'b1;
        step(1);
        idle_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung got=running exp=finished");
        finish_run();
    end

    initial begin
        // reset state: RUN, all clocks on (R9), no strobe (R10)
        do_reset();
        chk(G_RUN, "R9 reset");
        chk_pulse(1'b0, "R10 reset");

        // table walk: entry per mode (R1, R2, R4, R7, R8)
        for (int i = 0; i < 5; i++) begin
            do_reset();
            wdclk_ok = VEC[i][5];
            enter(VEC[i][7:6]);
            chk(VEC[i][4:0], "R1/R2/R4/R7/R8 table");
        end

        // R1: idle_req ignored while in STANDBY
        do_reset();
        enter(2'b01);
        enter(2'b10);
        chk(G_STBY, "R1 ignore req");

        // R3/R10: IDLE woken by interrupt
        do_reset();
        enter(2'b00);
        irq_n = 1'b0; step(1); irq_n = 1'b1;
        chk_pulse(1'b1, "R3 idle wake strobe");
        chk(G_RUN, "R3 idle clocks");
        step(1);
        chk_pulse(1'b0, "R10 strobe one cycle");
        chk(G_RUN, "R10 back in run");

        // R3: IDLE woken by watchdog
        do_reset();
        enter(2'b00);
        wdog_irq_n = 1'b0; step(1); wdog_irq_n = 1'b1;
        chk_pulse(1'b1, "R3 idle wdog wake");

        // R6: glitch of qual+1 clocks (qual=3 -> needs 5) rejected
        do_reset();
        enter(2'b01);
        gpio_n[0] = 1'b0; step(4); gpio_n[0] = 1'b1; step(1);
        chk(G_STBY, "R6 short pulse");
        // full length then R9 restore order, R10 strobe
        gpio_n[0] = 1'b0; step(4);
        chk(G_STBY, "R6 one short of length");
        step(1); gpio_n[0] = 1'b1;
        chk(G_UOSC, "R9 osc first");
        step(1);
        chk(G_UCPU, "R9 cpu second");
        step(1);
        chk(G_RUN, "R9 clkout third");
        chk_pulse(1'b0, "R10 no strobe yet");
        step(1);
        chk_pulse(1'b1, "R10 strobe");
        step(1);
        chk_pulse(1'b0, "R10 strobe ends");
        chk(G_RUN, "R10 run");

        // R6 boundary: qual=0 -> 2 clocks
        do_reset();
        qual_len = 6'd0;
        enter(2'b01);
        gpio_n[0] = 1'b0; step(1); gpio_n[0] = 1'b1; step(1);
        chk(G_STBY, "R6 min short");
        gpio_n[0] = 1'b0; step(2); gpio_n[0] = 1'b1;
        chk(G_UOSC, "R6 min accept");

        // R6 boundary: qual=63 -> 65 clocks
        do_reset();
        qual_len = 6'd63;
        enter(2'b01);
        gpio_n[0] = 1'b0; step(64);
        chk(G_STBY, "R6 max one short");
        step(1); gpio_n[0] = 1'b1;
        chk(G_UOSC, "R6 max accept");

        // R12: unselected line ignored in STANDBY and HALT
        do_reset();
        wake_sel = 32'h0000_0020;
        enter(2'b01);
        gpio_n[0] = 1'b0; step(10);
        chk(G_STBY, "R12 unselected standby");
        gpio_n[0] = 1'b1;
        do_reset();
        wake_sel = 32'h0000_0020;
        enter(2'b10);
        gpio_n[0] = 1'b0; step(3); gpio_n[0] = 1'b1;
        chk(G_HALT, "R12 unselected halt");

        // R5: debugger and watchdog end STANDBY at once
        do_reset();
        enter(2'b01);
        dbg_req_n = 1'b0; step(1); dbg_req_n = 1'b1;
        chk(G_UOSC, "R5 dbg wake");
        do_reset();
        enter(2'b01);
        wdog_irq_n = 1'b0; step(1); wdog_irq_n = 1'b1;
        chk(G_UOSC, "R5 wdog wake");

        // R7: dbg and irq ignored in HALT, GPIO unfiltered wakes
        do_reset();
        enter(2'b11);
        dbg_req_n = 1'b0; irq_n = 1'b0; step(3);
        dbg_req_n = 1'b1; irq_n = 1'b1;
        chk(G_HALT, "R7 halt ignores dbg/irq");
        gpio_n[0] = 1'b0; step(1); gpio_n[0] = 1'b1;
        chk(G_UOSC, "R7 halt gpio wake");
        do_reset();
        enter(2'b10);
        wdog_irq_n = 1'b0; step(1); wdog_irq_n = 1'b1;
        chk(G_UOSC, "R7 halt wdog wake");

        // R11: ext reset mid-filter returns to RUN and clears count
        do_reset();
        enter(2'b01);
        gpio_n[0] = 1'b0; step(3);
        ext_rst_n = 1'b0; step(1); ext_rst_n = 1'b1;
        chk(G_RUN, "R11 ext reset standby");
        enter(2'b01);
        step(3);
        chk(G_STBY, "R11 count cleared");
        gpio_n[0] = 1'b1;
        do_reset();
        enter(2'b10);
        ext_rst_n = 1'b0; step(1); ext_rst_n = 1'b1;
        chk(G_RUN, "R11 ext reset halt");

        finish_run();
    end
endmodule